// File: doc/BRIEF.md
# Circular Queue Pointer Manager

This block keeps the producer and consumer pointers of one circular queue held in memory, whose depth is chosen at run time as a power of two. Each pointer is an entry index plus a wrap flag that sits just above the index. That flag moves to a new bit position whenever the programmed size changes.

Software writes the producer pointer directly. A hardware producer may instead step it one entry at a time. The consumer logic steps the consumer pointer after each entry it has taken from the queue. The block reports full and empty from the two pointers. It also returns the byte address of the entry each pointer selects, computed from an aligned base address and a per-entry byte count.

The consumer register also holds a 7-bit error code. A consumer sets this code, and software clears it. While the code is non-zero, the consumer pointer is frozen. Pointer updates never disturb the stored code. Stepping of either pointer by hardware happens only while the global enable bit and this queue's enable bit are both set in the control word.

Top module: `cq_ptr_mgr`

## Requirements
- R1: A synchronous reset clears both pointers and the error code. After reset `q_empty` is 1 and `q_full` is 0.
- R2: `q_empty` is 1 exactly when the producer and consumer pointers are equal over their low L+1 bits, where L is the effective size exponent.
- R3: `q_full` is 1 exactly when the producer and consumer pointers, taken over their low L+1 bits, differ only in bit L, which is the wrap flag.
- R4: A software producer write (`prod_wr_en`) stores `prod_wr_data` masked to its low L+1 bits. This write takes priority over a hardware step in the same cycle.
- R5: `prod_adv` steps the producer to (producer+1) mod 2^(L+1). The index wraps to 0 and the wrap flag toggles. The step is ignored while the queue is full or inactive.
- R6: `cons_adv` steps the low L+1 bits of the consumer pointer modulo 2^(L+1). The error code at `cons_q[30:24]` is left unchanged. The step is ignored while the queue is empty or inactive.
- R7: `err_set` writes `err_code` into `cons_q[30:24]` and leaves the pointer unchanged. A consumer step requested in the same cycle is dropped. The code values are 0 for none, 1 for an illegal entry, 2 for an abort and 3 for a sync failure. If `err_set` and `err_clr` arrive together, `err_set` wins.
- R8: While the error code is non-zero, consumer steps are ignored. After `err_clr` writes the code back to 0, consumer steps resume.
- R9: `q_active` is `ctrl_word[0]` AND `ctrl_word[Q_EN_BIT]`. The default Q_EN_BIT is 3; a value of 2 is used for an event-side queue.
- R10: Each entry address is the base with bits 5:0 cleared, plus `entry_bytes` times the pointer index. The pointer index is the low L bits of the pointer. The sum is taken modulo 2^ADDR_W.
- R11: A programmed size exponent above 19 acts as 19, so L = min(`cfg_log2size`, 19).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_log2size | input | 5 | Queue depth exponent |
| cfg_base | input | ADDR_W (52) | Queue base address; bits 5:0 are ignored |
| cfg_entry_bytes | input | ESZ_W (8) | Bytes per entry |
| ctrl_word | input | 32 | Control word; bit 0 is the global enable, bit Q_EN_BIT is the queue enable |
| prod_wr_en | input | 1 | Software write strobe for the producer pointer |
| prod_wr_data | input | 32 | Software producer value |
| prod_adv | input | 1 | Hardware producer step request |
| cons_adv | input | 1 | Consumer step request |
| err_set | input | 1 | Load `err_code` into the error field |
| err_code | input | 7 | Error code to load |
| err_clr | input | 1 | Clear the error field |
| prod_q | output | 32 | Producer register readback |
| cons_q | output | 32 | Consumer register readback; error field at bits 30:24 |
| q_full | output | 1 | Queue full |
| q_empty | output | 1 | Queue empty |
| q_active | output | 1 | Hardware stepping is enabled |
| prod_addr | output | ADDR_W (52) | Byte address of the producer entry |
| cons_addr | output | ADDR_W (52) | Byte address of the consumer entry |

## Verification
A wrong pointer value or a lost wrap toggle shows on `prod_q` or `cons_q` one clock after the faulty update. It shows in the same cycle on `q_full`, `q_empty` and the entry addresses, because those are decoded without further registers. A corrupted error field, or a consumer that keeps moving while an error is pending, shows in `cons_q` on the next clock. The bench keeps its own pointer, error and address model in plain integers and compares every output once per clock. Any divergence is therefore reported within one cycle of its cause. This holds across size changes, saturation at full and empty, and disabled periods.

// File: rtl/cq_pkg.sv
package cq_pkg;
    localparam int REG_W   = 32;
    localparam int ERR_W   = 7;
    localparam int ERR_LSB = 24;

    typedef enum logic [ERR_W-1:0] {
        CQ_ERR_NONE    = 7'd0,
        CQ_ERR_ILLEGAL = 7'd1,
        CQ_ERR_ABORT   = 7'd2,
        CQ_ERR_SYNC    = 7'd3
    } cq_err_e;

    typedef struct packed {
        logic full;
        logic empty;
        logic active;
    } cq_status_t;

    function automatic logic [REG_W-1:0] onehot_at(input int unsigned pos);
        return REG_W'(1) << pos;
    endfunction
endpackage

// File: rtl/cq_geometry.sv
module cq_geometry #(
    parameter int MAX_LOG2 = 19,
    parameter int LOG_W    = 5,
    localparam int PTR_W   = MAX_LOG2 + 1
) (
    input  logic [LOG_W-1:0] log2size,
    output logic [PTR_W-1:0] wrap_bit,
    output logic [PTR_W-1:0] idx_mask,
    output logic [PTR_W-1:0] span_mask
);
    import cq_pkg::*;
    logic [LOG_W-1:0] l_eff;

    always_comb begin
        l_eff     = (int'(log2size) > MAX_LOG2) ? LOG_W'(MAX_LOG2) : log2size;
        wrap_bit  = PTR_W'(onehot_at(int'(l_eff)));
        idx_mask  = wrap_bit - PTR_W'(1);
        span_mask = idx_mask | wrap_bit;
    end
endmodule

// File: rtl/cq_prod_ptr.sv
module cq_prod_ptr #(
    parameter int PTR_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] span_mask,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_data,
    input  logic             step,
    input  logic             full,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)        ptr <= '0;
        else if (wr_en) ptr <= wr_data & span_mask;
        else if (step)  ptr <= (ptr + PTR_W'(1)) & span_mask;
    end

    assert_prod_in_span_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((ptr & ~$past(span_mask)) == '0));

    assert_no_step_when_full_R5: assert property (@(posedge clk) disable iff (rst)
        (full && !wr_en) |=> $stable(ptr));
endmodule

// File: rtl/cq_cons_ptr.sv
module cq_cons_ptr #(
    parameter int PTR_W = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PTR_W-1:0]        span_mask,
    input  logic                    step,
    input  logic                    err_set,
    input  cq_pkg::cq_err_e         err_code,
    input  logic                    err_clr,
    output logic [PTR_W-1:0]        ptr,
    output logic [cq_pkg::ERR_W-1:0] err
);
    import cq_pkg::*;
    logic halted;
    assign halted = (err != '0) || err_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            err <= '0;
        end else begin
            if (err_set)      err <= err_code;
            else if (err_clr) err <= '0;
            if (step && !halted) ptr <= (ptr + PTR_W'(1)) & span_mask;
        end
    end

    assert_err_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (!err_set && !err_clr) |=> $stable(err));

    assert_set_holds_ptr_R7: assert property (@(posedge clk) disable iff (rst)
        err_set |=> $stable(ptr));

    assert_err_freezes_R8: assert property (@(posedge clk) disable iff (rst)
        (err != '0) |=> $stable(ptr));
endmodule

// File: rtl/cq_entry_addr.sv
module cq_entry_addr #(
    parameter int ADDR_W     = 52,
    parameter int ESZ_W      = 8,
    parameter int PTR_W      = 20,
    parameter int BASE_ALIGN = 6,
    localparam int OFF_W     = ESZ_W + PTR_W
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ESZ_W-1:0]  entry_bytes,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [PTR_W-1:0]  idx_mask,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base_al;
    logic [OFF_W-1:0]  offset;

    always_comb begin
        base_al = base & ~ADDR_W'((64'd1 << BASE_ALIGN) - 64'd1);
        offset  = OFF_W'(entry_bytes) * OFF_W'(ptr & idx_mask);
        addr    = base_al + ADDR_W'(offset);
    end
endmodule

// File: rtl/cq_ptr_mgr.sv
module cq_ptr_mgr #(
    parameter int MAX_LOG2   = 19,
    parameter int ADDR_W     = 52,
    parameter int ESZ_W      = 8,
    parameter int Q_EN_BIT   = 3,
    parameter int BASE_ALIGN = 6,
    localparam int PTR_W     = MAX_LOG2 + 1,
    localparam int LOG_W     = $clog2(MAX_LOG2 + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LOG_W-1:0]         cfg_log2size,
    input  logic [ADDR_W-1:0]        cfg_base,
    input  logic [ESZ_W-1:0]         cfg_entry_bytes,
    input  logic [31:0]              ctrl_word,
    input  logic                     prod_wr_en,
    input  logic [31:0]              prod_wr_data,
    input  logic                     prod_adv,
    input  logic                     cons_adv,
    input  logic                     err_set,
    input  logic [6:0]               err_code,
    input  logic                     err_clr,
    output logic [31:0]              prod_q,
    output logic [31:0]              cons_q,
    output logic                     q_full,
    output logic                     q_empty,
    output logic                     q_active,
    output logic [ADDR_W-1:0]        prod_addr,
    output logic [ADDR_W-1:0]        cons_addr
);
    import cq_pkg::*;

    logic [PTR_W-1:0] wrap_bit, idx_mask, span_mask;
    logic [PTR_W-1:0] prod_ptr, cons_ptr, diff;
    logic [ERR_W-1:0] err_q;
    cq_status_t       st;
    logic [PTR_W-1:0] side_ptr [2];
    logic [ADDR_W-1:0] side_addr [2];

    cq_geometry #(.MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W)) u_geo (
        .log2size(cfg_log2size), .wrap_bit(wrap_bit),
        .idx_mask(idx_mask), .span_mask(span_mask)
    );

    always_comb begin
        diff      = (prod_ptr ^ cons_ptr) & span_mask;
        st.active = ctrl_word[0] & ctrl_word[Q_EN_BIT];
        st.empty  = (diff == '0);
        st.full   = (diff == wrap_bit);
    end

    cq_prod_ptr #(.PTR_W(PTR_W)) u_prod (
        .clk(clk), .rst(rst), .span_mask(span_mask),
        .wr_en(prod_wr_en), .wr_data(prod_wr_data[PTR_W-1:0]),
        .step(prod_adv && st.active && !st.full), .full(st.full),
        .ptr(prod_ptr)
    );

    cq_cons_ptr #(.PTR_W(PTR_W)) u_cons (
        .clk(clk), .rst(rst), .span_mask(span_mask),
        .step(cons_adv && st.active && !st.empty),
        .err_set(err_set), .err_code(cq_err_e'(err_code)), .err_clr(err_clr),
        .ptr(cons_ptr), .err(err_q)
    );

    assign side_ptr[0] = prod_ptr;
    assign side_ptr[1] = cons_ptr;

    for (genvar g = 0; g < 2; g++) begin : g_addr
        cq_entry_addr #(
            .ADDR_W(ADDR_W), .ESZ_W(ESZ_W), .PTR_W(PTR_W), .BASE_ALIGN(BASE_ALIGN)
        ) u_addr (
            .base(cfg_base), .entry_bytes(cfg_entry_bytes),
            .ptr(side_ptr[g]), .idx_mask(idx_mask), .addr(side_addr[g])
        );
    end

    assign prod_addr = side_addr[0];
    assign cons_addr = side_addr[1];
    assign prod_q    = {{(REG_W-PTR_W){1'b0}}, prod_ptr};
    assign cons_q    = {1'b0, err_q, {(ERR_LSB-PTR_W){1'b0}}, cons_ptr};
    assign q_full    = st.full;
    assign q_empty   = st.empty;
    assign q_active  = st.active;

    assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(q_full && q_empty));

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (prod_ptr == '0 && cons_ptr == '0 && err_q == '0));

    assert_inactive_prod_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!q_active && !prod_wr_en) |=> $stable(prod_ptr));

    assert_inactive_cons_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !q_active |=> $stable(cons_ptr));
endmodule

// File: tb/cq_ptr_mgr_test.sv
module cq_ptr_mgr_test;
    logic        clk = 0;
    logic        rst = 1;
    logic [4:0]  cfg_log2size = 5'd2;
    logic [51:0] cfg_base = 52'h1_2345_6789_ABF;
    logic [7:0]  cfg_entry_bytes = 8'd16;
    logic [31:0] ctrl_word = 32'h9;
    logic        prod_wr_en = 0;
    logic [31:0] prod_wr_data = 0;
    logic        prod_adv = 0, cons_adv = 0, err_set = 0, err_clr = 0;
    logic [6:0]  err_code = 0;
    logic [31:0] prod_q, cons_q;
    logic        q_full, q_empty, q_active;
    logic [51:0] prod_addr, cons_addr;

    int vectors = 0, miscompares = 0;
    string req = "R1";
    longint unsigned m_prod = 0, m_cons = 0, m_err = 0;

    always #2 clk = ~clk;

    cq_ptr_mgr uut (.*);

    function automatic int unsigned eff_l();
        return (cfg_log2size > 19) ? 19 : int'(cfg_log2size);
    endfunction
    function automatic longint unsigned span();
        return (64'd1 << (eff_l() + 1)) - 1;
    endfunction
    function automatic longint unsigned wrapb();
        return 64'd1 << eff_l();
    endfunction
    function automatic bit m_active();
        return ctrl_word[0] && ctrl_word[3];
    endfunction
    function automatic bit m_empty();
        return ((m_prod ^ m_cons) & span()) == 0;
    endfunction
    function automatic bit m_full();
        return ((m_prod ^ m_cons) & span()) == wrapb();
    endfunction
    function automatic longint unsigned m_addr(longint unsigned p);
        longint unsigned a;
        a = (longint'(cfg_base) & ~64'h3F) + longint'(cfg_entry_bytes) * (p & (wrapb() - 1));
        return a & ((64'd1 << 52) - 1);
    endfunction

    task automatic cmp(string r, string what, longint unsigned act, longint unsigned exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic model_update();
        bit pf, ce, act;
        longint unsigned olderr;
        pf = m_full(); ce = m_empty(); act = m_active(); olderr = m_err;
        if (rst) begin
            m_prod = 0; m_cons = 0; m_err = 0;
        end else begin
            if (prod_wr_en) m_prod = prod_wr_data & span();
            else if (prod_adv && act && !pf) m_prod = (m_prod + 1) & span();
            if (err_set) m_err = err_code;
            else if (err_clr) m_err = 0;
            if (cons_adv && act && !ce && olderr == 0 && !err_set)
                m_cons = (m_cons + 1) & span();
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        cmp((req == "R1") ? "R1" : "R4/R5", "prod_q", prod_q, m_prod);
        cmp((req == "R1") ? "R1" : "R6/R7/R8", "cons_q", cons_q, (m_err << 24) | m_cons);
        cmp("R3", "q_full", q_full, m_full());
        cmp("R2", "q_empty", q_empty, m_empty());
        cmp("R9", "q_active", q_active, m_active());
        cmp("R10", "prod_addr", prod_addr, m_addr(m_prod));
        cmp("R10", "cons_addr", cons_addr, m_addr(m_cons));
        if (req != "") cmp(req, "phase check", 0, 0);
        prod_wr_en = 0; prod_adv = 0; cons_adv = 0; err_set = 0; err_clr = 0;
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        req = "R1";
        repeat (3) tick();
        rst = 0;
        // R5: fill past full with 4-entry queue, extra steps ignored
        req = "R5";
        repeat (7) begin prod_adv = 1; tick(); end
        // R6: drain past empty
        req = "R6";
        repeat (6) begin cons_adv = 1; tick(); end
        // R4: masked software write plus priority over step
        req = "R4";
        prod_wr_data = 32'hFFFF_FFFF; prod_wr_en = 1; prod_adv = 1; tick();
        prod_wr_data = 32'h0000_0006; prod_wr_en = 1; tick();
        // R7: error set drops simultaneous step
        req = "R7";
        err_code = 7'd2; err_set = 1; cons_adv = 1; tick();
        // R8: steps ignored while error pending
        req = "R8";
        repeat (3) begin cons_adv = 1; tick(); end
        err_code = 7'd1; err_set = 1; err_clr = 1; tick();
        err_clr = 1; tick();
        repeat (2) begin cons_adv = 1; tick(); end
        req = "R7";
        err_code = 7'd3; err_set = 1; tick();
        err_clr = 1; tick();
        // R9: missing either enable blocks stepping
        req = "R9";
        ctrl_word = 32'h1;
        repeat (2) begin prod_adv = 1; cons_adv = 1; tick(); end
        ctrl_word = 32'h8;
        repeat (2) begin prod_adv = 1; cons_adv = 1; tick(); end
        ctrl_word = 32'h4;
        prod_adv = 1; tick();
        ctrl_word = 32'hD;
        // R11: oversized exponent clamps to 19
        req = "R11";
        cfg_log2size = 5'd25;
        prod_wr_data = 32'hFFFF_FFFF; prod_wr_en = 1; tick();
        repeat (3) begin prod_adv = 1; tick(); end
        cons_adv = 1; tick();
        // R10: address with other base and entry size
        req = "R10";
        cfg_base = 52'hF_FFFF_FFFF_FFC5; cfg_entry_bytes = 8'd32;
        prod_wr_data = 32'h7_FFFF; prod_wr_en = 1; tick();
        tick();
        // R2: random mix across sizes
        req = "R2";
        rst = 1; tick(); rst = 0;
        for (int i = 0; i < 600; i++) begin
            if (i % 50 == 0) cfg_log2size = 5'($urandom_range(0, 5));
            ctrl_word     = ($urandom_range(0, 9) == 0) ? 32'h1 : 32'h9;
            prod_adv      = ($urandom_range(0, 2) != 0);
            cons_adv      = ($urandom_range(0, 2) != 0);
            prod_wr_en    = ($urandom_range(0, 30) == 0);
            prod_wr_data  = $urandom;
            err_set       = ($urandom_range(0, 40) == 0);
            err_code      = 7'($urandom_range(0, 3));
            err_clr       = ($urandom_range(0, 6) == 0);
            cfg_entry_bytes = 8'($urandom);
            tick();
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule